// File: doc/BRIEF.md
# Raster Timing Generator

This block produces horizontal and vertical timing for a raster display in the pixel clock domain. The horizontal axis and the vertical axis are each programmed with four values: a sync pulse width, a gate delay (back porch), an active gate length and a total length. From two free-running counters it drives horizontal sync, vertical sync, composite sync and a blanking strobe. Each of these four outputs has its own polarity bit. While video is active it also reports the column and row of the current pixel, and it gives a one-cycle marker on the first cycle of every frame.

The timing words come from a register file elsewhere and must be stable while they are sampled. The block copies them into shadow registers once in the first cycle after reset, and again on the clock edge that closes each frame. A write in the middle of a frame therefore takes effect at the next frame boundary. Pixel data fetch and clock generation are outside the block. A downstream pipeline uses the blanking strobe to qualify pixel data, and it uses the indices to address that data.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, every output is low. In the first cycle after reset is released every output is still low while the parameters are loaded. The first frame's pixel 0 of line 0 appears on the outputs in the second cycle after release.
- R2: Timing word layout. `h_timing_i` and `v_timing_i` each carry the sync width in bits 31:24, the gate delay in bits 23:16 and the active gate in bits 15:0. `totals_i` carries the horizontal total in bits 31:16 and the vertical total in bits 15:0.
- R3: A line lasts hlen+1 clocks, with a horizontal position h running from 0 to hlen. Horizontal sync is active for h <= hsw. The gate delay occupies the next hgd+1 clocks. The active pixels are h = hsw+hgd+2 through hsw+hgd+2+hgt, which is hgt+1 pixels. The line is blanked up to hlen.
- R4: A frame lasts vlen+1 lines, and the vertical position v advances once per completed line. Vertical sync is active on lines v <= vsw. The active lines are v = vsw+vgd+2 through vsw+vgd+2+vgt.
- R5: The blanking strobe is active unless both the horizontal and the vertical positions lie in their active windows.
- R6: During active video `pix_x_o` equals h minus the first active h and `pix_y_o` equals v minus the first active v. Both outputs read 0 while blanked.
- R7: Composite sync is the XOR of the active-sense horizontal and vertical sync, with the composite polarity applied afterwards.
- R8: Polarity input bit 0 inverts hsync, bit 1 inverts vsync, bit 2 inverts csync and bit 3 inverts blank. A 0 gives an active-high sync and an active-high blank.
- R9: `frame_start_o` is high for exactly one cycle: the cycle that shows pixel 0 of line 0. In that cycle both syncs are active and the output is blanked.
- R10: The timing words and the polarity bits are sampled only at a frame boundary. A change in the middle of a frame leaves the current frame untouched and governs the next frame completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_timing_i | input | 32 | Horizontal sync width, gate delay, active gate |
| v_timing_i | input | 32 | Vertical sync width, gate delay, active gate |
| totals_i | input | 32 | Horizontal total (upper half), vertical total (lower half) |
| pol_i | input | 4 | Polarity inversions: hsync, vsync, csync, blank |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Blanking strobe |
| pix_x_o | output | 16 | Column index within the active area |
| pix_y_o | output | 16 | Row index within the active area |
| frame_start_o | output | 1 | One-cycle marker on the first cycle of a frame |

## Verification
The assertions assume that on each axis the active window ends at or before the total length, so that sync, gate delay and active gate all fit inside one line or one frame. They also assume a line is long enough that the frame marker cannot repeat in consecutive cycles. The bench programs only such settings. It switches between three of them, including a one-pixel, one-line active area. Every input change is made well inside a frame, so each boundary load sees stable words.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int SYNC_W = 8;
  localparam int DEL_W  = 8;
  localparam int GATE_W = 16;
  localparam int LEN_W  = 16;
  localparam int TIM_W  = SYNC_W + DEL_W + GATE_W;
  localparam int TOT_W  = 2 * LEN_W;
  localparam int CALC_W = LEN_W + 2;
  localparam int NAX    = 2;
  localparam int AX_H   = 0;
  localparam int AX_V   = 1;
  localparam int POL_W  = 4;
  localparam int POL_HS = 0;
  localparam int POL_VS = 1;
  localparam int POL_CS = 2;
  localparam int POL_BL = 3;

  typedef struct packed {
    logic [SYNC_W-1:0] sw;
    logic [DEL_W-1:0]  gd;
    logic [GATE_W-1:0] gt;
    logic [LEN_W-1:0]  len;
  } axis_cfg_t;

  function automatic axis_cfg_t unpack_axis(input logic [TIM_W-1:0] tim,
                                            input logic [LEN_W-1:0] len);
    axis_cfg_t c;
    c.sw  = tim[TIM_W-1 -: SYNC_W];
    c.gd  = tim[GATE_W +: DEL_W];
    c.gt  = tim[GATE_W-1:0];
    c.len = len;
    return c;
  endfunction

  function automatic logic [CALC_W-1:0] act_first(input axis_cfg_t c);
    return CALC_W'(c.sw) + CALC_W'(c.gd) + CALC_W'(2);
  endfunction

  function automatic logic [CALC_W-1:0] act_last(input axis_cfg_t c);
    return act_first(c) + CALC_W'(c.gt);
  endfunction

  function automatic logic sync_hit(input logic [LEN_W-1:0] cnt, input axis_cfg_t c);
    return CALC_W'(cnt) <= CALC_W'(c.sw);
  endfunction

  function automatic logic act_hit(input logic [LEN_W-1:0] cnt, input axis_cfg_t c);
    logic [CALC_W-1:0] wide;
    wide = CALC_W'(cnt);
    return (wide >= act_first(c)) && (wide <= act_last(c));
  endfunction

  function automatic logic [LEN_W-1:0] act_offset(input logic [LEN_W-1:0] cnt,
                                                  input axis_cfg_t c);
    logic [CALC_W-1:0] d;
    d = CALC_W'(cnt) - act_first(c);
    return d[LEN_W-1:0];
  endfunction
endpackage

// File: rtl/rtg_axis_counter.sv
module rtg_axis_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = step && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (step)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/rtg_axis_decode.sv
module rtg_axis_decode
  import rtg_pkg::*;
(
  input  axis_cfg_t        cfg,
  input  logic [LEN_W-1:0] cnt,
  output logic             in_sync,
  output logic             in_act,
  output logic [LEN_W-1:0] offs
);
  assign in_sync = sync_hit(cnt, cfg);
  assign in_act  = act_hit(cnt, cfg);
  assign offs    = act_offset(cnt, cfg);
endmodule

// File: rtl/rtg_cfg_shadow.sv
module rtg_cfg_shadow
  import rtg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [TIM_W-1:0]      h_tim,
  input  logic [TIM_W-1:0]      v_tim,
  input  logic [TOT_W-1:0]      totals,
  input  logic [POL_W-1:0]      pol_in,
  output axis_cfg_t [NAX-1:0]   cfg,
  output logic [POL_W-1:0]      pol
);
  logic [TIM_W-1:0]    tim_sel [NAX];
  axis_cfg_t [NAX-1:0] nxt;

  assign tim_sel[AX_H] = h_tim;
  assign tim_sel[AX_V] = v_tim;

  for (genvar a = 0; a < NAX; a++) begin : g_unpack
    assign nxt[a] = unpack_axis(tim_sel[a], totals[TOT_W-1-a*LEN_W -: LEN_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
      pol <= '0;
    end else if (load) begin
      cfg <= nxt;
      pol <= pol_in;
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       h_timing_i,
  input  logic [31:0]       v_timing_i,
  input  logic [31:0]       totals_i,
  input  logic [3:0]        pol_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              csync_o,
  output logic              blank_o,
  output logic [15:0]       pix_x_o,
  output logic [15:0]       pix_y_o,
  output logic              frame_start_o
);
  logic                running;
  logic                load_ev;
  axis_cfg_t [NAX-1:0] cfg_s;
  logic [POL_W-1:0]    pol_s;
  logic [NAX-1:0]      step, wrap, sync_v, act_v;
  logic [LEN_W-1:0]    cnt  [NAX];
  logic [LEN_W-1:0]    offs [NAX];
  logic [LEN_W-1:0]    h_cnt, v_cnt;
  logic                video_on, frame_begin;
  logic                video_on_q;
  logic [POL_W-1:0]    pol_q;

  // first cycle after reset loads the shadow; counting starts after it
  always_ff @(posedge clk) begin
    if (!rst_n) running <= 1'b0;
    else        running <= 1'b1;
  end

  assign load_ev = !running || wrap[AX_V];

  rtg_cfg_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_ev),
    .h_tim  (h_timing_i),
    .v_tim  (v_timing_i),
    .totals (totals_i),
    .pol_in (pol_i),
    .cfg    (cfg_s),
    .pol    (pol_s)
  );

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    if (a == 0) begin : g_first
      assign step[a] = running;
    end else begin : g_chain
      assign step[a] = wrap[a-1];
    end

    rtg_axis_counter #(.W(LEN_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step[a]),
      .last  (cfg_s[a].len),
      .cnt   (cnt[a]),
      .wrap  (wrap[a])
    );

    rtg_axis_decode u_dec (
      .cfg     (cfg_s[a]),
      .cnt     (cnt[a]),
      .in_sync (sync_v[a]),
      .in_act  (act_v[a]),
      .offs    (offs[a])
    );
  end

  assign h_cnt       = cnt[AX_H];
  assign v_cnt       = cnt[AX_V];
  assign video_on    = act_v[AX_H] && act_v[AX_V];
  assign frame_begin = (h_cnt == '0) && (v_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !running) begin
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      csync_o       <= 1'b0;
      blank_o       <= 1'b0;
      pix_x_o       <= '0;
      pix_y_o       <= '0;
      frame_start_o <= 1'b0;
      video_on_q    <= 1'b0;
      pol_q         <= '0;
    end else begin
      hsync_o       <= sync_v[AX_H] ^ pol_s[POL_HS];
      vsync_o       <= sync_v[AX_V] ^ pol_s[POL_VS];
      csync_o       <= (sync_v[AX_H] ^ sync_v[AX_V]) ^ pol_s[POL_CS];
      blank_o       <= !video_on ^ pol_s[POL_BL];
      pix_x_o       <= video_on ? offs[AX_H] : '0;
      pix_y_o       <= video_on ? offs[AX_V] : '0;
      frame_start_o <= frame_begin;
      video_on_q    <= video_on;
      pol_q         <= pol_s;
    end
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                hsync_o,
  input logic                vsync_o,
  input logic                csync_o,
  input logic                blank_o,
  input logic [LEN_W-1:0]    pix_x_o,
  input logic [LEN_W-1:0]    pix_y_o,
  input logic                frame_start_o,
  input logic                video_on_q,
  input logic [POL_W-1:0]    pol_q,
  input logic                load_ev,
  input axis_cfg_t [NAX-1:0] cfg_s,
  input logic [POL_W-1:0]    pol_s,
  input logic [LEN_W-1:0]    h_cnt,
  input logic [LEN_W-1:0]    v_cnt
);
  logic hs_act, vs_act;
  assign hs_act = hsync_o ^ pol_q[POL_HS];
  assign vs_act = vsync_o ^ pol_q[POL_VS];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt <= cfg_s[AX_H].len) && (v_cnt <= cfg_s[AX_V].len)); // R3
  AST_CSYNC_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (csync_o ^ pol_q[POL_CS]) == (hs_act ^ vs_act)); // R7
  AST_BLANK_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    video_on_q |-> (blank_o == pol_q[POL_BL])); // R5
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !video_on_q |-> (pix_x_o == '0) && (pix_y_o == '0)); // R6
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on_q && $past(video_on_q)) |-> (pix_x_o == $past(pix_x_o) + LEN_W'(1))); // R6
  AST_FS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> hs_act && vs_act && !video_on_q); // R9
  AST_FS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o); // R9
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(cfg_s) && $stable(pol_s)); // R10
endmodule

bind raster_timing_gen rtg_checker u_rtg_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .hsync_o       (hsync_o),
  .vsync_o       (vsync_o),
  .csync_o       (csync_o),
  .blank_o       (blank_o),
  .pix_x_o       (pix_x_o),
  .pix_y_o       (pix_y_o),
  .frame_start_o (frame_start_o),
  .video_on_q    (video_on_q),
  .pol_q         (pol_q),
  .load_ev       (load_ev),
  .cfg_s         (cfg_s),
  .pol_s         (pol_s),
  .h_cnt         (h_cnt),
  .v_cnt         (v_cnt)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] h_timing_i, v_timing_i, totals_i;
  logic [3:0]  pol_i;
  logic        hsync_o, vsync_o, csync_o, blank_o, frame_start_o;
  logic [15:0] pix_x_o, pix_y_o;

  always #10 clk = ~clk; // 50 MHz

  raster_timing_gen i_raster_timing_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .h_timing_i    (h_timing_i),
    .v_timing_i    (v_timing_i),
    .totals_i      (totals_i),
    .pol_i         (pol_i),
    .hsync_o       (hsync_o),
    .vsync_o       (vsync_o),
    .csync_o       (csync_o),
    .blank_o       (blank_o),
    .pix_x_o       (pix_x_o),
    .pix_y_o       (pix_y_o),
    .frame_start_o (frame_start_o)
  );

  typedef struct {
    logic hs, vs, cs, bl, fs;
    int   x, y;
    int   fr;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // R2 field layout: sync [31:24], gate delay [23:16], gate [15:0]; totals {h, v}
  task automatic apply(input int hsw, input int hgd, input int hgt, input int hlen,
                       input int vsw, input int vgd, input int vgt, input int vlen,
                       input logic [3:0] pol);
    h_timing_i = {8'(hsw), 8'(hgd), 16'(hgt)};
    v_timing_i = {8'(vsw), 8'(vgd), 16'(vgt)};
    totals_i   = {16'(hlen), 16'(vlen)};
    pol_i      = pol;
  endtask

  // driver: expected output of every cycle of one frame
  task automatic push_frame(input int hsw, input int hgd, input int hgt, input int hlen,
                            input int vsw, input int vgd, input int vgt, input int vlen,
                            input logic [3:0] pol, input int fr);
    exp_t e;
    int   h0, v0;
    logic hs, vs, ha, va;
    h0 = hsw + 1 + hgd + 1;
    v0 = vsw + 1 + vgd + 1;
    for (int v = 0; v < vlen + 1; v++) begin
      for (int h = 0; h < hlen + 1; h++) begin
        hs = (h < hsw + 1);
        vs = (v < vsw + 1);
        ha = (h >= h0) && (h < h0 + hgt + 1);
        va = (v >= v0) && (v < v0 + vgt + 1);
        e.hs = hs ^ pol[0];
        e.vs = vs ^ pol[1];
        e.cs = (hs != vs) ^ pol[2];
        e.bl = !(ha && va) ^ pol[3];
        e.x  = (ha && va) ? h - h0 : 0;
        e.y  = (ha && va) ? v - v0 : 0;
        e.fs = (h == 0) && (v == 0);
        e.fr = fr;
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    exp_t  e;
    string ft;
    int    idx;
    push_frame(1, 0, 3, 11, 0, 0, 2, 5, 4'b0000, 1);
    push_frame(2, 1, 4, 12, 1, 1, 1, 7, 4'b1111, 2);
    push_frame(0, 0, 0, 4, 0, 2, 0, 5, 4'b0101, 3);
    apply(1, 0, 3, 11, 0, 0, 2, 5, 4'b0000);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "hsync in reset", int'(hsync_o), 0);
    chk("R1", "vsync in reset", int'(vsync_o), 0);
    chk("R1", "csync in reset", int'(csync_o), 0);
    chk("R1", "blank in reset", int'(blank_o), 0);
    chk("R1", "frame marker in reset", int'(frame_start_o), 0);
    chk("R1", "x in reset", int'(pix_x_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "hsync in load cycle", int'(hsync_o), 0);
    chk("R1", "blank in load cycle", int'(blank_o), 0);
    chk("R1", "frame marker in load cycle", int'(frame_start_o), 0);
    @(negedge clk);
    idx = 0;
    // monitor: pop one expected item per cycle and compare
    while (exp_q.size() > 0) begin
      e  = exp_q.pop_front();
      ft = (e.fr == 1) ? "R2" : (e.fr == 2) ? "R10 R8" : "R8 R10";
      chk($sformatf("R3 %s", ft), "hsync", int'(hsync_o), int'(e.hs));
      chk($sformatf("R4 %s", ft), "vsync", int'(vsync_o), int'(e.vs));
      chk($sformatf("R7 %s", ft), "csync", int'(csync_o), int'(e.cs));
      chk($sformatf("R5 %s", ft), "blank", int'(blank_o), int'(e.bl));
      chk($sformatf("R6 %s", ft), "pix_x", int'(pix_x_o), e.x);
      chk($sformatf("R6 %s", ft), "pix_y", int'(pix_y_o), e.y);
      chk($sformatf("R9 %s", ft), "frame_start", int'(frame_start_o), int'(e.fs));
      if (idx == 30)  apply(2, 1, 4, 12, 1, 1, 1, 7, 4'b1111); // R10 mid-frame write
      if (idx == 122) apply(0, 0, 0, 4, 0, 2, 0, 5, 4'b0101);  // R10 mid-frame write
      idx++;
      @(negedge clk);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule